// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block runs a chain of two-word DMA script instructions stored in memory. The host starts a run by writing a start address into the script pointer. The sequencer reads two consecutive 32-bit words at that address and takes the top byte of the first word as the opcode. For a block-move opcode it passes a 24-bit byte count and a 32-bit target address to an external data mover. It then waits for the mover to finish, steps the pointer past the instruction and fetches the next one.

A run stops on an interrupt opcode, an unknown opcode or a misaligned start address. The sequencer then raises a host interrupt with a status code and goes idle until the host restarts it. Memory reads use a request/valid handshake: the request and address stay up until the memory returns a word.

Top module: `script_fetch_seq`

## Requirements
- R1: After reset the block is idle: busy, irq, memReq and moveStart are 0, irqCode is 0 and scriptPtr is 0.
- R2: A host pointer write accepted while idle with an 8-byte aligned value loads scriptPtr and starts a fetch. The fetch issues exactly two reads, at the written address and then at that address plus 4.
- R3: The opcode is bits 31:24 of the first word, and 8'h01 means block move. For a block move with a non-zero count, moveStart pulses for one cycle with moveCount equal to bits 23:0 of the first word and moveAddr equal to the whole second word.
- R4: After moveDone the next fetch starts at the instruction address plus 8, and scriptPtr shows that advanced value.
- R5: A block move whose count field is zero produces no moveStart pulse and goes straight on to the next instruction, 8 bytes further.
- R6: Opcode 8'h02 stops the run with irq = 1, irqCode = 1 (interrupt opcode), busy = 0 and scriptPtr advanced past the interrupt instruction.
- R7: Any other opcode stops the run with irq = 1, irqCode = 2 (illegal opcode), and scriptPtr is left at the faulting instruction.
- R8: An accepted pointer write whose low 3 bits are not all zero issues no memory read. It sets irq = 1 with irqCode = 3 (misaligned) and leaves scriptPtr at the written value.
- R9: A pointer write while busy is ignored: the fetch addresses, the moves and the final scriptPtr are the same as without it.
- R10: A hostClrIrq pulse returns irq and irqCode to 0 without changing scriptPtr. An accepted pointer write also clears them in the next cycle.
- R11: While memReq is high and memValid is low, memReq stays high and memAddr keeps its value in the next cycle.
- R12: A moveDone pulse that arrives while no block move is pending has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostPtrWe | input | 1 | Host write strobe for the script pointer |
| hostPtrData | input | 32 | Value written to the script pointer |
| hostClrIrq | input | 1 | Host pulse that clears the interrupt and its code |
| scriptPtr | output | 32 | Current script pointer, readable by the host |
| busy | output | 1 | High while a run is in progress |
| irq | output | 1 | Host interrupt |
| irqCode | output | 2 | Stop cause: 0 none, 1 interrupt opcode, 2 illegal opcode, 3 misaligned |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memValid | input | 1 | Read data valid; completes the current request |
| memData | input | 32 | Read data |
| moveStart | output | 1 | One-cycle start pulse to the data mover |
| moveCount | output | 24 | Byte count for the mover |
| moveAddr | output | 32 | Memory start address for the mover |
| moveDone | input | 1 | Mover completion pulse |

## Verification
Four properties are checked on every cycle:
- the memory request holds its address until it is served;
- reads fall only on the two word slots of an aligned instruction;
- moveStart is a single-cycle pulse that never carries a zero count;
- irq and irqCode agree, and nothing is issued while irq is up.

Some behaviour can only be shown by the directed scenarios:
- the order of fetch addresses across a chain;
- the decoded count and address values;
- where the pointer rests after each kind of stop;
- that a write while busy or a stray completion changes nothing.

// File: rtl/scrseq_pkg.sv
package scrseq_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int OP_W   = 8;
  localparam int CNT_W  = 24;

  localparam logic [OP_W-1:0] OP_MOVE = 8'h01;
  localparam logic [OP_W-1:0] OP_INT  = 8'h02;

  typedef enum logic [1:0] {
    CODE_NONE    = 2'd0,
    CODE_INTOP   = 2'd1,
    CODE_ILLEGAL = 2'd2,
    CODE_ALIGN   = 2'd3
  } code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_DECODE,
    ST_MOVE
  } state_e;

  typedef struct packed {
    logic  loadPtr;
    logic  advPtr;
    logic  capLo;
    logic  capHi;
    logic  selHi;
    logic  setIrq;
    logic  clrIrq;
    code_e code;
  } strobe_t;
endpackage

// File: rtl/scrseq_dp.sv
module scrseq_dp
  import scrseq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W,
  parameter int OW = OP_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [AW-1:0] hostData,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] memAddr,
  output logic [OW-1:0] opcode,
  output logic [CW-1:0] moveCount,
  output logic [AW-1:0] moveAddr,
  output logic          countZero,
  output logic          hostAligned,
  output logic          irq,
  output logic [1:0]    irqCode
);
  localparam int WORD_BYTES  = DW / 8;
  localparam int INSTR_BYTES = 2 * WORD_BYTES;
  localparam int ALIGN_BITS  = $clog2(INSTR_BYTES);

  logic [DW-1:0] wordLo;
  logic [DW-1:0] wordHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      wordLo <= '0;
      wordHi <= '0;
    end else begin
      if (strobe.loadPtr)     ptr <= hostData;
      else if (strobe.advPtr) ptr <= ptr + AW'(INSTR_BYTES);
      if (strobe.capLo) wordLo <= memData;
      if (strobe.capHi) wordHi <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq     <= 1'b0;
      irqCode <= CODE_NONE;
    end else if (strobe.setIrq) begin
      irq     <= 1'b1;
      irqCode <= strobe.code;
    end else if (strobe.clrIrq) begin
      irq     <= 1'b0;
      irqCode <= CODE_NONE;
    end
  end

  assign memAddr     = strobe.selHi ? ptr + AW'(WORD_BYTES) : ptr;
  assign opcode      = wordLo[DW-1 -: OW];
  assign moveCount   = wordLo[CW-1:0];
  assign moveAddr    = wordHi[AW-1:0];
  assign countZero   = (wordLo[CW-1:0] == '0);
  assign hostAligned = (hostData[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/scrseq_ctrl.sv
module scrseq_ctrl
  import scrseq_pkg::*;
#(
  parameter int OW = OP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostPtrWe,
  input  logic          hostClrIrq,
  input  logic          hostAligned,
  input  logic          memValid,
  input  logic          moveDone,
  input  logic [OW-1:0] opcode,
  input  logic          countZero,
  output strobe_t       strobe,
  output logic          memReq,
  output logic          moveStart,
  output logic          busy
);
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    strobe        = '0;
    strobe.code   = CODE_NONE;
    strobe.clrIrq = hostClrIrq;
    moveStart     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (hostPtrWe) begin
          strobe.loadPtr = 1'b1;
          strobe.clrIrq  = 1'b1;
          if (hostAligned) begin
            stateNext = ST_FETCH0;
          end else begin
            strobe.setIrq = 1'b1;
            strobe.code   = CODE_ALIGN;
          end
        end
      end
      ST_FETCH0: begin
        strobe.capLo = memValid;
        if (memValid) stateNext = ST_FETCH1;
      end
      ST_FETCH1: begin
        strobe.selHi = 1'b1;
        strobe.capHi = memValid;
        if (memValid) stateNext = ST_DECODE;
      end
      ST_DECODE: begin
        if (opcode == OP_MOVE) begin
          strobe.advPtr = 1'b1;
          if (countZero) begin
            stateNext = ST_FETCH0;
          end else begin
            moveStart = 1'b1;
            stateNext = ST_MOVE;
          end
        end else if (opcode == OP_INT) begin
          strobe.advPtr = 1'b1;
          strobe.setIrq = 1'b1;
          strobe.code   = CODE_INTOP;
          stateNext     = ST_IDLE;
        end else begin
          strobe.setIrq = 1'b1;
          strobe.code   = CODE_ILLEGAL;
          stateNext     = ST_IDLE;
        end
      end
      ST_MOVE: begin
        if (moveDone) stateNext = ST_FETCH0;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_FETCH0) || (state == ST_FETCH1);
  assign busy   = (state != ST_IDLE);
endmodule

// File: rtl/script_fetch_seq.sv
module script_fetch_seq
  import scrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostPtrWe,
  input  logic [ADDR_W-1:0] hostPtrData,
  input  logic              hostClrIrq,
  output logic [ADDR_W-1:0] scriptPtr,
  output logic              busy,
  output logic              irq,
  output logic [1:0]        irqCode,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData,
  output logic              moveStart,
  output logic [CNT_W-1:0]  moveCount,
  output logic [ADDR_W-1:0] moveAddr,
  input  logic              moveDone
);
  strobe_t         strobe;
  logic [OP_W-1:0] opcode;
  logic            countZero;
  logic            hostAligned;

  scrseq_ctrl #(.OW(OP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostPtrWe(hostPtrWe), .hostClrIrq(hostClrIrq),
    .hostAligned(hostAligned), .memValid(memValid), .moveDone(moveDone),
    .opcode(opcode), .countZero(countZero), .strobe(strobe),
    .memReq(memReq), .moveStart(moveStart), .busy(busy)
  );

  scrseq_dp #(.AW(ADDR_W), .DW(WORD_W), .OW(OP_W), .CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostData(hostPtrData),
    .memData(memData), .ptr(scriptPtr), .memAddr(memAddr), .opcode(opcode),
    .moveCount(moveCount), .moveAddr(moveAddr), .countZero(countZero),
    .hostAligned(hostAligned), .irq(irq), .irqCode(irqCode)
  );
endmodule

// File: rtl/scrseq_chk.sv
module scrseq_chk
  import scrseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              moveStart,
  input logic [CNT_W-1:0]  moveCount,
  input logic              busy,
  input logic              irq,
  input logic [1:0]        irqCode
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  // R2
  fetch_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[2:0] == 3'd0 || memAddr[2:0] == 3'd4));

  // R3
  move_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    moveStart |=> !moveStart);

  // R5
  move_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    moveStart |-> moveCount != '0);

  // R10
  irq_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq || !memReq |-> irq == (irqCode != 2'd0));

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busy && !memReq && !moveStart);
endmodule

bind script_fetch_seq scrseq_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memValid(memValid),
  .memAddr(memAddr), .moveStart(moveStart), .moveCount(moveCount),
  .busy(busy), .irq(irq), .irqCode(irqCode)
);

// File: tb/tb_script_fetch_seq.sv
module tb_script_fetch_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostPtrWe = 1'b0;
  logic [31:0] hostPtrData = '0;
  logic        hostClrIrq = 1'b0;
  logic [31:0] scriptPtr;
  logic        busy, irq;
  logic [1:0]  irqCode;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        moveStart;
  logic [23:0] moveCount;
  logic [31:0] moveAddr;
  logic        moveDone = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mem [256];
  int          memLat = 0;
  int          wcnt = 0;
  logic [31:0] heldAddr = '0;
  bit          holdBad = 0;
  logic [31:0] rdAddr [32];
  int          rdN = 0;

  int          moveLat = 0;
  int          mcnt = 0;
  bit          pend = 0;
  bit          prevStart = 0;
  bit          pulseBad = 0;
  bit          strayReq = 0;
  logic [23:0] mvCount [8];
  logic [31:0] mvAddr [8];
  int          mvN = 0;

  script_fetch_seq dut (
    .clk(clk), .rstN(rstN), .hostPtrWe(hostPtrWe), .hostPtrData(hostPtrData),
    .hostClrIrq(hostClrIrq), .scriptPtr(scriptPtr), .busy(busy), .irq(irq),
    .irqCode(irqCode), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .moveStart(moveStart), .moveCount(moveCount),
    .moveAddr(moveAddr), .moveDone(moveDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model
  always @(negedge clk) begin
    if (memValid) begin
      memValid = 1'b0;
      wcnt = 0;
    end else if (memReq) begin
      if (wcnt > 0 && memAddr != heldAddr) holdBad = 1;
      heldAddr = memAddr;
      if (wcnt >= memLat) begin
        memValid = 1'b1;
        memData = mem[memAddr[9:2]];
        if (rdN < 32) rdAddr[rdN] = memAddr;
        rdN++;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  // mover model
  always @(negedge clk) begin
    moveDone = 1'b0;
    if (moveStart) begin
      if (prevStart) pulseBad = 1;
      if (!prevStart && mvN < 8) begin
        mvCount[mvN] = moveCount;
        mvAddr[mvN] = moveAddr;
        mvN++;
      end
      pend = 1;
      mcnt = moveLat;
    end else if (pend) begin
      if (mcnt == 0) begin
        moveDone = 1'b1;
        pend = 0;
      end else begin
        mcnt--;
      end
    end
    if (strayReq) begin
      moveDone = 1'b1;
      strayReq = 0;
    end
    prevStart = moveStart;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putInstr(input logic [31:0] addr, input logic [31:0] w0, input logic [31:0] w1);
    mem[addr[9:2]] = w0;
    mem[addr[9:2] + 8'd1] = w1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    rdN = 0; mvN = 0; holdBad = 0; pulseBad = 0; pend = 0;
    memLat = 0; moveLat = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [31:0] v);
    @(negedge clk);
    hostPtrWe = 1'b1;
    hostPtrData = v;
    @(negedge clk);
    hostPtrWe = 1'b0;
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    check(irq == 1'b1, "R6 run stops with irq", 32'(irq), 32'd1);
  endtask

  task automatic loadChain();
    putInstr(32'h100, 32'h0100_0040, 32'hA000_0000);
    putInstr(32'h108, 32'h0112_3456, 32'h1234_5678);
    putInstr(32'h110, 32'h0200_0000, 32'h0000_0000);
  endtask

  task automatic checkChain(input string tag);
    logic [31:0] expAddr [6];
    expAddr = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h110, 32'h114};
    check(rdN == 6, {tag, " R2 read count"}, 32'(rdN), 32'd6);
    for (int i = 0; i < 6; i++)
      check(rdAddr[i] == expAddr[i], {tag, " R2/R4 fetch address"}, rdAddr[i], expAddr[i]);
    check(mvN == 2, {tag, " R3 move count"}, 32'(mvN), 32'd2);
    check(mvCount[0] == 24'h000040, {tag, " R3 count0"}, 32'(mvCount[0]), 32'h40);
    check(mvAddr[0] == 32'hA000_0000, {tag, " R3 addr0"}, mvAddr[0], 32'hA000_0000);
    check(mvCount[1] == 24'h123456, {tag, " R3 count1"}, 32'(mvCount[1]), 32'h123456);
    check(mvAddr[1] == 32'h1234_5678, {tag, " R3 addr1"}, mvAddr[1], 32'h1234_5678);
    check(irqCode == 2'd1, {tag, " R6 code"}, 32'(irqCode), 32'd1);
    check(scriptPtr == 32'h118, {tag, " R6 ptr past int"}, scriptPtr, 32'h118);
    check(busy == 1'b0, {tag, " R6 idle"}, 32'(busy), 32'd0);
    check(pulseBad == 0, {tag, " R3 single-cycle pulse"}, 32'(pulseBad), 32'd0);
  endtask

  task automatic t_reset();
    doReset();
    check(busy == 0 && irq == 0 && memReq == 0 && moveStart == 0, "R1 reset controls",
          {28'd0, busy, irq, memReq, moveStart}, 32'd0);
    check(irqCode == 0, "R1 reset code", 32'(irqCode), 32'd0);
    check(scriptPtr == 0, "R1 reset ptr", scriptPtr, 32'd0);
  endtask

  task automatic t_chain();
    doReset();
    loadChain();
    memLat = 3;
    moveLat = 2;
    hostWrite(32'h100);
    waitIrq();
    checkChain("chain");
    check(holdBad == 0, "R11 request held", 32'(holdBad), 32'd0);
  endtask

  task automatic t_zeroCount();
    doReset();
    putInstr(32'h200, 32'h0100_0000, 32'hDEAD_0000);
    putInstr(32'h208, 32'h0100_0005, 32'h5555_0000);
    putInstr(32'h210, 32'h0200_0000, 32'h0);
    hostWrite(32'h200);
    waitIrq();
    check(mvN == 1, "R5 zero count skipped", 32'(mvN), 32'd1);
    check(mvCount[0] == 24'd5, "R5 next move count", 32'(mvCount[0]), 32'd5);
    check(rdN == 6, "R5 continues to next", 32'(rdN), 32'd6);
    check(scriptPtr == 32'h218, "R5 ptr", scriptPtr, 32'h218);
  endtask

  task automatic t_illegal();
    doReset();
    putInstr(32'h300, 32'h0100_0008, 32'h0BAD_0000);
    putInstr(32'h308, 32'h7F00_0000, 32'h0);
    hostWrite(32'h300);
    waitIrq();
    check(irqCode == 2'd2, "R7 illegal code", 32'(irqCode), 32'd2);
    check(scriptPtr == 32'h308, "R7 ptr stays", scriptPtr, 32'h308);
    check(mvN == 1, "R7 prior move ran", 32'(mvN), 32'd1);
  endtask

  task automatic t_misalignAndRestart();
    doReset();
    loadChain();
    hostWrite(32'h404);
    repeat (4) @(negedge clk);
    check(rdN == 0, "R8 no read", 32'(rdN), 32'd0);
    check(irq == 1 && irqCode == 2'd3, "R8 misaligned code", 32'(irqCode), 32'd3);
    check(scriptPtr == 32'h404, "R8 ptr holds write", scriptPtr, 32'h404);
    hostWrite(32'h100);
    check(irq == 0 && irqCode == 0, "R10 write clears irq", 32'(irqCode), 32'd0);
    check(busy == 1, "R2 write starts run", 32'(busy), 32'd1);
    waitIrq();
    checkChain("restart");
  endtask

  task automatic t_clear();
    doReset();
    loadChain();
    hostWrite(32'h100);
    waitIrq();
    @(negedge clk);
    hostClrIrq = 1'b1;
    @(negedge clk);
    hostClrIrq = 1'b0;
    check(irq == 0, "R10 clear irq", 32'(irq), 32'd0);
    check(irqCode == 0, "R10 clear code", 32'(irqCode), 32'd0);
    check(scriptPtr == 32'h118, "R10 ptr kept", scriptPtr, 32'h118);
  endtask

  task automatic t_busyWriteStray();
    doReset();
    loadChain();
    memLat = 3;
    moveLat = 6;
    hostWrite(32'h100);
    @(posedge clk);
    strayReq = 1;
    repeat (3) @(negedge clk);
    check(busy == 1 && mvN == 0, "R12 stray done ignored", 32'(mvN), 32'd0);
    hostWrite(32'h300);
    waitIrq();
    checkChain("busy-write R9 R12");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    t_reset();
    t_chain();
    t_zeroCount();
    t_illegal();
    t_misalignAndRestart();
    t_clear();
    t_busyWriteStray();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule